// File: doc/BRIEF.md
# Truncating Single-Precision to Signed Integer Converter

This block turns one IEEE-754 binary32 value into a signed integer, always discarding the fraction (round toward zero). The operand comes in on a wide vector input, and only the lowest 32-bit lane is used. A width select chooses a signed 32-bit or signed 64-bit destination. Both widths share one shift-and-negate datapath.

Each conversion is started by a one-cycle valid strobe. The result, an invalid-operation flag, a precision (inexact) flag, a result write enable and a fault pulse are all registered. They appear together one clock later. When a conversion is invalid, the result is the fixed indefinite integer. If the invalid exception is left unmasked, the write enable is dropped and the fault output pulses instead.

Top module: `fp32_to_int_trunc`

## Requirements
- R1: Only bits [31:0] of `in_vec` are converted. Bits above 31 have no effect on any output.
- R2: An in-range finite input produces the value truncated toward zero, for both positive and negative inputs. The result is in two's complement.
- R3: With `wide_sel`=0, the result is a signed 32-bit value in `out_data[31:0]` and `out_data[63:32]` is zero. With `wide_sel`=1, all 64 bits hold the signed result.
- R4: `flag_invalid` is set in these cases: the input is NaN (exponent field 255, fraction nonzero), the input is either infinity, or the truncated value lies outside the signed range of the chosen width. Exactly -2^31 in 32-bit mode, and exactly -2^63 in 64-bit mode, convert with no flag.
- R5: On an invalid conversion with `inv_mask`=1, `out_data` is 0x0000_0000_8000_0000 in 32-bit mode or 0x8000_0000_0000_0000 in 64-bit mode, `out_we`=1 and `fault`=0.
- R6: On an invalid conversion with `inv_mask`=0, `fault`=1 and `out_we`=0 in the cycle where `out_valid` is high.
- R7: `flag_inexact` is set when nonzero fraction bits are discarded. Both zeros give 0 with no flags. Nonzero denormals, and every magnitude below 1.0, give 0 with `flag_inexact`=1.
- R8: `flag_inexact` is never set together with `flag_invalid`.
- R9: All outputs follow `in_valid` by exactly one clock. `out_valid` is high only in the cycle after a strobe, and the synchronous active-high `rst` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Start strobe for one conversion |
| in_vec | input | 128 | Vector operand; lane [31:0] is converted |
| wide_sel | input | 1 | 0: 32-bit destination, 1: 64-bit destination |
| inv_mask | input | 1 | 1: invalid exception masked |
| out_valid | output | 1 | Result valid, one clock after `in_valid` |
| out_data | output | 64 | Converted integer |
| out_we | output | 1 | Result write enable |
| flag_invalid | output | 1 | Invalid-operation status |
| flag_inexact | output | 1 | Precision status |
| fault | output | 1 | Unmasked invalid exception pulse |

## Verification
There are two pairs of functions that land in the same output cycle. The first pair is range checking and sign negation. They meet at the most negative value of each width, where one extra unit of magnitude separates a legal result from an invalid one. The bench drives ±2^31 and ±2^63 in both widths, and also random values near those exponents. The second pair is invalid detection and precision reporting. These meet on NaNs with nonzero payloads, and on non-integers in both masking states. For each, the bench compares the flags, the write enable and the fault pulse against a reference model that works through a wide fixed-point magnitude rather than an exponent-limited shift.

// File: rtl/fp32_to_int_trunc.sv
module fp32_to_int_trunc #(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] in_vec,
  input  logic             wide_sel,
  input  logic             inv_mask,
  output logic             out_valid,
  output logic [63:0]      out_data,
  output logic             out_we,
  output logic             flag_invalid,
  output logic             flag_inexact,
  output logic             fault
);
  localparam int BIAS = 127;
  localparam int MANT = 23;

  logic        sgn;
  logic [7:0]  expo;
  logic [22:0] frac;
  logic [23:0] sig;
  logic [8:0]  k;
  logic [8:0]  lim;
  logic [5:0]  shl;
  logic [4:0]  shr;
  logic [63:0] mag, sval, indef, res;
  logic        inv, inx;

  assign sgn   = in_vec[31];
  assign expo  = in_vec[30:23];
  assign frac  = in_vec[22:0];
  assign sig   = {1'b1, frac};
  assign k     = {1'b0, expo} - 9'(BIAS);
  assign lim   = wide_sel ? 9'd63 : 9'd31;
  assign shl   = k[5:0] - 6'(MANT);
  assign shr   = 5'(MANT) - k[4:0];
  assign indef = wide_sel ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;

  always_comb begin
    inv = 1'b0;
    inx = 1'b0;
    mag = '0;
    if (expo == 8'hFF) begin
      inv = 1'b1;
    end else if (expo < 8'(BIAS)) begin
      inx = (expo != 8'd0) || (frac != 23'd0);
    end else if (k >= lim) begin
      if (sgn && k == lim && frac == 23'd0) mag = 64'd1 << lim[5:0];
      else inv = 1'b1;
    end else if (k >= 9'(MANT)) begin
      mag = {40'd0, sig} << shl;
    end else begin
      mag = {40'd0, sig} >> shr;
      inx = (sig & ((24'd1 << shr) - 24'd1)) != 24'd0;
    end
  end

  assign sval = sgn ? (~mag + 64'd1) : mag;
  assign res  = inv ? indef : (wide_sel ? sval : {32'd0, sval[31:0]});

  always_ff @(posedge clk) begin
    if (rst) out_valid <= 1'b0;
    else     out_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_data     <= '0;
      flag_invalid <= 1'b0;
      flag_inexact <= 1'b0;
      out_we       <= 1'b0;
      fault        <= 1'b0;
    end else begin
      out_we <= in_valid && !(inv && !inv_mask);
      fault  <= in_valid && inv && !inv_mask;
      if (in_valid) begin
        out_data     <= res;
        flag_invalid <= inv;
        flag_inexact <= inx && !inv;
      end
    end
  end
endmodule

// File: rtl/fp32_to_int_trunc_chk.sv
module fp32_to_int_trunc_chk (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        wide_sel,
  input logic        inv_mask,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic        out_we,
  input logic        flag_invalid,
  input logic        flag_inexact,
  input logic        fault
);
  p_valid_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_valid_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  p_narrow_upper_zero_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_sel) |=> (out_data[63:32] == 32'd0));
  p_masked_indef_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && inv_mask) ##1 (out_valid && flag_invalid) |->
      (out_we && !fault && (out_data == 64'h8000_0000_0000_0000 ||
                            out_data == 64'h0000_0000_8000_0000)));
  p_fault_blocks_write_r6: assert property (@(posedge clk) disable iff (rst)
    fault |-> (out_valid && flag_invalid && !out_we));
  p_no_inexact_on_invalid_r8: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(flag_invalid && flag_inexact));
  p_we_needs_valid_r9: assert property (@(posedge clk) disable iff (rst)
    (out_we || fault) |-> out_valid);
endmodule

bind fp32_to_int_trunc fp32_to_int_trunc_chk u_chk (.*);

// File: tb/fp32_to_int_trunc_tb_top.sv
module fp32_to_int_trunc_tb_top;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_vec = '0;
  logic         wide_sel = 1'b0;
  logic         inv_mask = 1'b1;
  logic         out_valid, out_we, flag_invalid, flag_inexact, fault;
  logic [63:0]  out_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp32_to_int_trunc dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_vec(in_vec),
    .wide_sel(wide_sel), .inv_mask(inv_mask), .out_valid(out_valid),
    .out_data(out_data), .out_we(out_we), .flag_invalid(flag_invalid),
    .flag_inexact(flag_inexact), .fault(fault)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic void ref_conv(input logic [31:0] f, input logic w,
                                   output logic [63:0] d, output logic inv, output logic inx);
    logic [127:0] mag, lim, val;
    int e, sh;
    logic [23:0] sig;
    e = int'(f[30:23]);
    mag = '0;
    inv = 1'b0;
    inx = 1'b0;
    lim = w ? (128'd1 << 63) : (128'd1 << 31);
    if (e == 255) begin
      inv = 1'b1;
    end else if (e == 0) begin
      inx = (f[22:0] != 0);
    end else begin
      sig = {1'b1, f[22:0]};
      if (e >= 150) mag = {104'd0, sig} << (e - 150);
      else begin
        sh = 150 - e;
        if (sh >= 24) inx = 1'b1;
        else begin
          mag = {104'd0, sig >> sh};
          inx = ((mag << sh) != {104'd0, sig});
        end
      end
      inv = f[31] ? (mag > lim) : (mag >= lim);
    end
    if (inv) begin
      inx = 1'b0;
      d = w ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
    end else begin
      val = f[31] ? (~mag + 128'd1) : mag;
      d = w ? val[63:0] : {32'd0, val[31:0]};
    end
  endfunction

  task automatic run(input logic [31:0] f, input logic w, input logic m, input logic [95:0] hi);
    logic [63:0] ed;
    logic ei, ex;
    ref_conv(f, w, ed, ei, ex);
    @(negedge clk);
    in_vec = {hi, f};
    wide_sel = w;
    inv_mask = m;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    in_vec = ~in_vec;
    wide_sel = ~w;
    chk("R9 out_valid", {63'd0, out_valid}, 64'd1);
    chk(ei ? "R4/R5 data" : (w ? "R2 data wide" : "R2/R3 data narrow"), out_data, ed);
    chk("R4 invalid", {63'd0, flag_invalid}, {63'd0, ei});
    chk("R7/R8 inexact", {63'd0, flag_inexact}, {63'd0, ex});
    chk("R5/R6 write enable", {63'd0, out_we}, {63'd0, !(ei && !m)});
    chk("R6 fault", {63'd0, fault}, {63'd0, ei && !m});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9 reset out_valid", {63'd0, out_valid}, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 idle out_valid", {63'd0, out_valid}, 64'd0);

    run(32'h0000_0000, 0, 1, '0);      // R7 +0
    run(32'h8000_0000, 1, 1, '0);      // R7 -0
    run(32'h3FC0_0000, 0, 1, '0);      // R2 1.5
    run(32'hBFC0_0000, 1, 1, '0);      // R2 -1.5
    run(32'h3F00_0000, 0, 1, '0);      // R7 0.5
    run(32'h0000_0001, 1, 1, '0);      // R7 denormal
    run(32'h4F00_0000, 0, 1, '0);      // R4 2^31 narrow
    run(32'h4F00_0000, 1, 1, '0);      // R4 2^31 wide ok
    run(32'hCF00_0000, 0, 1, '0);      // R4 -2^31 narrow ok
    run(32'hCF00_0001, 0, 0, '0);      // R6 just below -2^31
    run(32'hDF00_0000, 1, 1, '0);      // R4 -2^63 wide ok
    run(32'h5F00_0000, 1, 0, '0);      // R6 2^63 unmasked
    run(32'h7FC0_1234, 0, 1, '0);      // R8 NaN with payload
    run(32'h7F80_0000, 1, 0, '0);      // R4 +inf
    run(32'hFF80_0000, 0, 1, '0);      // R4 -inf
    run(32'hC2F6_E979, 0, 1, {96{1'b1}}); // R1 upper bits set
    run(32'hC2F6_E979, 0, 1, '0);      // R1 upper bits clear

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] f;
      f = $urandom;
      if (i % 4 != 0) f[30:23] = 8'(100 + ($urandom % 100));
      run(f, 1'($urandom), 1'($urandom), {$urandom, $urandom, $urandom});
    end

    @(negedge clk);
    chk("R9 valid drops", {63'd0, out_valid}, 64'd0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule